// File: doc/BRIEF.md
# TDM Codec Slot Port

This block is the codec end of a time-division-multiplexed serial link to a signal processor. A frame holds sixteen 16-bit slots. The first two slots carry control words, the next eight carry conversion samples, and the last six stay empty. On transmit, the block takes parallel words from internal logic and shifts each one out in its slot. On receive, it gathers the serial bits of each slot into a word and hands that word back with a strobe. The strobe carries the slot index.

The block runs from one system clock. As a slave it follows a bit clock and frame marker driven by the processor, and it oversamples both. As a master it divides the system clock to make the bit clock and the frame marker itself, then feeds them back through the same receive path. The control slots are used only while the control-mode select input is low.

Top module: `tdm_slot_port`

## Requirements
- R1: A frame is 256 bit-clock periods long, split into 16 slots of 16 bits. Slot k covers bit positions 16k to 16k+15. If no new frame marker arrives, the bit position wraps from 255 to 0 and the next frame starts.
- R2: When the frame marker is sampled high on a falling bit-clock edge, the next rising edge starts bit 0 of slot 0. This also applies in the middle of a frame, where it resynchronises the slot counter.
- R3: Words go out and come in most significant bit first. `dout` changes only after a rising bit-clock edge. `din` is captured on falling edges, so the received word for a slot equals the 16 bits the far end sent in it.
- R4: The transmit word for slot s (0 to 9) is `tx_words[16*s +: 16]`. Slots 2 to 9 always send their word. Slots 0 and 1 send theirs only when `ctl_mode_n` is 0.
- R5: `dout` is 0 for every bit of slots 10 to 15. It is also 0 for every bit of slots 0 and 1 while `ctl_mode_n` is 1.
- R6: One system-clock cycle after the 16th bit of a slot is captured, `rx_valid` pulses for exactly one cycle. At the same time `rx_slot` gives the slot index and `rx_word` gives the word. This happens for slots 2 to 9, and for slots 0 and 1 only when `ctl_mode_n` is 0. Slots 10 to 15 never raise a strobe.
- R7: When `master_en` is 1, `bclk_o` has a period of 2*BCLK_HALF system clocks. `fsync_o` is high for exactly one bit-clock period, the one holding bit 255, and changes only together with a rising `bclk_o` edge. When `master_en` is 0, both outputs are 0.
- R8: After reset, and until the first frame marker has been seen, `dout` stays 0 and no strobe is raised, whatever the bit clock and `din` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1: generate bit clock and frame marker; 0: follow external ones |
| ctl_mode_n | input | 1 | 0: slots 0 and 1 carry control words; 1: they are muted and ignored |
| bclk_i | input | 1 | External bit clock (slave mode) |
| fsync_i | input | 1 | External frame marker (slave mode) |
| din | input | 1 | Serial receive data |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| fsync_o | output | 1 | Generated frame marker (master mode) |
| dout | output | 1 | Serial transmit data |
| tx_words | input | 160 | Transmit words, slot s at bits 16*s+15 down to 16*s |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_slot | output | 4 | Slot index of the received word |
| rx_word | output | 16 | Received word |

## Verification
The bench targets four things:
- **Mute logic.** It runs frames with control mode on and off, using all-ones and all-zeros patterns. A design that leaked a control word while muted, or shifted anything into the vacant slots, would show non-zero bits there.
- **Resynchronisation.** It drops a frame marker part-way through slot 2 and then checks the next full frame. A counter that ignored the early marker would send every word shifted by the leftover bit count.
- **Wrap without a marker.** It also runs a frame with no marker at all.
- **Idle after reset and master timing.** It clocks the port before any marker and expects silence. In master mode it measures the marker width and its position in the frame, where an off-by-one generator would put the marker over bit 0 or make it two periods wide.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam int SLOT_W        = 16;
    localparam int SLOT_BITS_W   = $clog2(SLOT_W);
    localparam int NUM_SLOTS     = 16;
    localparam int SLOT_IDX_W    = $clog2(NUM_SLOTS);
    localparam int POS_W         = SLOT_BITS_W + SLOT_IDX_W;
    localparam int CTL_SLOTS     = 2;
    localparam int DATA_SLOTS    = 8;
    localparam int ACTIVE_SLOTS  = CTL_SLOTS + DATA_SLOTS;
    localparam int TX_BUS_W      = ACTIVE_SLOTS * SLOT_W;

    localparam logic [SLOT_IDX_W-1:0] FIRST_DATA_SLOT   = SLOT_IDX_W'(CTL_SLOTS);
    localparam logic [SLOT_IDX_W-1:0] FIRST_VACANT_SLOT = SLOT_IDX_W'(ACTIVE_SLOTS);

    typedef struct packed {
        logic [2:0] bclk;
        logic [1:0] fsync;
        logic [1:0] data;
    } sync_st_t;

    typedef struct packed {
        logic                  active;
        logic                  fs_pend;
        logic [POS_W-1:0]      bitpos;
        logic [SLOT_W-1:0]     tx_sh;
        logic                  dout;
        logic [SLOT_W-1:0]     rx_sh;
        logic                  rx_valid;
        logic [SLOT_IDX_W-1:0] rx_slot;
        logic [SLOT_W-1:0]     rx_word;
    } eng_st_t;
endpackage

// File: rtl/tdm_bclk_gen.sv
module tdm_bclk_gen
    import tdm_pkg::*;
#(
    parameter int BCLK_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic bclk,
    output logic fsync
);
    localparam int DIV_W = $clog2(2 * BCLK_HALF);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(2 * BCLK_HALF - 1);
    localparam logic [DIV_W-1:0] DIV_MID  = DIV_W'(BCLK_HALF - 1);
    localparam logic [POS_W-1:0] POS_LAST = '1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             bclk;
        logic             fsync;
        logic [POS_W-1:0] mbit;
    } gen_st_t;

    localparam gen_st_t GEN_RST = '{div: '0, bclk: 1'b0, fsync: 1'b0,
                                    mbit: POS_LAST - POS_W'(1)};

    gen_st_t q, d;

    always_comb begin
        d = q;
        if (!en) begin
            d = GEN_RST;
        end else if (q.div == DIV_LAST) begin
            d.div   = '0;
            d.bclk  = 1'b1;
            d.mbit  = q.mbit + 1'b1;
            d.fsync = (d.mbit == POS_LAST);
        end else begin
            d.div = q.div + 1'b1;
            if (q.div == DIV_MID) d.bclk = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= GEN_RST;
        else        q <= d;
    end

    assign bclk  = q.bclk;
    assign fsync = q.fsync;

    AST_FSYNC_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n || !en)
        !$stable(q.fsync) |-> $rose(q.bclk)); // R7
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en) && !en |-> !q.bclk && !q.fsync); // R7
endmodule

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync
    import tdm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic fsync_in,
    input  logic din_in,
    output logic rise,
    output logic fall,
    output logic fsync_s,
    output logic din_s
);
    sync_st_t q, d;

    always_comb begin
        d       = q;
        d.bclk  = {q.bclk[1:0], bclk_in};
        d.fsync = {q.fsync[0], fsync_in};
        d.data  = {q.data[0], din_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise    =  q.bclk[1] & ~q.bclk[2];
    assign fall    = ~q.bclk[1] &  q.bclk[2];
    assign fsync_s =  q.fsync[1];
    assign din_s   =  q.data[1];

    AST_EDGES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall)); // R3
endmodule

// File: rtl/tdm_slot_engine.sv
module tdm_slot_engine
    import tdm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rise,
    input  logic                  fall,
    input  logic                  fsync_s,
    input  logic                  din_s,
    input  logic                  ctl_mode_n,
    input  logic [TX_BUS_W-1:0]   tx_words,
    output logic                  dout,
    output logic                  rx_valid,
    output logic [SLOT_IDX_W-1:0] rx_slot,
    output logic [SLOT_W-1:0]     rx_word
);
    logic [SLOT_W-1:0] tx_arr [ACTIVE_SLOTS];

    for (genvar g = 0; g < ACTIVE_SLOTS; g++) begin : g_tx
        assign tx_arr[g] = tx_words[g*SLOT_W +: SLOT_W];
    end

    eng_st_t q, d;

    always_comb begin
        logic [POS_W-1:0]      nxt;
        logic                  load;
        logic [SLOT_W-1:0]     word;
        logic [SLOT_IDX_W-1:0] sl_rx;
        logic [SLOT_IDX_W-1:0] sl_tx;
        d          = q;
        d.rx_valid = 1'b0;
        nxt        = q.bitpos;
        load       = 1'b0;
        word       = {q.tx_sh[SLOT_W-2:0], 1'b0};
        sl_rx      = q.bitpos[POS_W-1:SLOT_BITS_W];
        sl_tx      = '0;

        if (fall) begin
            d.fs_pend = fsync_s;
            if (q.active) begin
                d.rx_sh = {q.rx_sh[SLOT_W-2:0], din_s};
                if (&q.bitpos[SLOT_BITS_W-1:0] && sl_rx < FIRST_VACANT_SLOT &&
                    (sl_rx >= FIRST_DATA_SLOT || !ctl_mode_n)) begin
                    d.rx_valid = 1'b1;
                    d.rx_slot  = sl_rx;
                    d.rx_word  = d.rx_sh;
                end
            end
        end

        if (rise && (q.fs_pend || q.active)) begin
            if (q.fs_pend) begin
                nxt       = '0;
                load      = 1'b1;
                d.active  = 1'b1;
                d.fs_pend = 1'b0;
            end else begin
                nxt  = q.bitpos + 1'b1;
                load = (nxt[SLOT_BITS_W-1:0] == '0);
            end
            sl_tx = nxt[POS_W-1:SLOT_BITS_W];
            if (load) begin
                word = '0;
                for (int s = 0; s < ACTIVE_SLOTS; s++) begin
                    if (sl_tx == SLOT_IDX_W'(s) && (s >= CTL_SLOTS || !ctl_mode_n))
                        word = tx_arr[s];
                end
            end
            d.bitpos = nxt;
            d.tx_sh  = word;
            d.dout   = word[SLOT_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout     = q.dout;
    assign rx_valid = q.rx_valid;
    assign rx_slot  = q.rx_slot;
    assign rx_word  = q.rx_word;

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.rx_valid |=> !q.rx_valid); // R6
    AST_NO_VACANT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        q.rx_valid |-> q.rx_slot < FIRST_VACANT_SLOT); // R6
    AST_CTL_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        q.rx_valid && q.rx_slot < FIRST_DATA_SLOT |-> !$past(ctl_mode_n)); // R6
    AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.dout) |-> $past(rise)); // R3
    AST_IDLE_UNTIL_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !q.active |-> !q.dout && !q.rx_valid); // R8
    AST_RESYNC_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rise && q.fs_pend) |-> q.bitpos == '0); // R2
    AST_VACANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        q.bitpos[POS_W-1:SLOT_BITS_W] >= FIRST_VACANT_SLOT |-> !q.dout); // R5
endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
    import tdm_pkg::*;
#(
    parameter int BCLK_HALF = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  master_en,
    input  logic                  ctl_mode_n,
    input  logic                  bclk_i,
    input  logic                  fsync_i,
    input  logic                  din,
    output logic                  bclk_o,
    output logic                  fsync_o,
    output logic                  dout,
    input  logic [TX_BUS_W-1:0]   tx_words,
    output logic                  rx_valid,
    output logic [SLOT_IDX_W-1:0] rx_slot,
    output logic [SLOT_W-1:0]     rx_word
);
    logic gen_bclk, gen_fsync;
    logic bclk_src, fsync_src;
    logic rise, fall, fsync_s, din_s;

    tdm_bclk_gen #(.BCLK_HALF(BCLK_HALF)) gen_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (master_en),
        .bclk  (gen_bclk),
        .fsync (gen_fsync)
    );

    assign bclk_src  = master_en ? gen_bclk  : bclk_i;
    assign fsync_src = master_en ? gen_fsync : fsync_i;
    assign bclk_o    = gen_bclk;
    assign fsync_o   = gen_fsync;

    tdm_edge_sync sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_in  (bclk_src),
        .fsync_in (fsync_src),
        .din_in   (din),
        .rise     (rise),
        .fall     (fall),
        .fsync_s  (fsync_s),
        .din_s    (din_s)
    );

    tdm_slot_engine eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .fall       (fall),
        .fsync_s    (fsync_s),
        .din_s      (din_s),
        .ctl_mode_n (ctl_mode_n),
        .tx_words   (tx_words),
        .dout       (dout),
        .rx_valid   (rx_valid),
        .rx_slot    (rx_slot),
        .rx_word    (rx_word)
    );
endmodule

// File: tb/tdm_slot_port_tb_top.sv
module tdm_slot_port_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         master_en = 1'b0;
    logic         ctl_mode_n = 1'b0;
    logic         bclk_i = 1'b0;
    logic         fsync_i = 1'b0;
    logic         din = 1'b0;
    logic         bclk_o, fsync_o, dout;
    logic [159:0] tx_words = '0;
    logic         rx_valid;
    logic [3:0]   rx_slot;
    logic [15:0]  rx_word;

    int checks = 0;
    int failures = 0;

    logic [15:0] din_w [16];
    logic [15:0] got_dout [16];
    int          rx_total [16] = '{default: 0};
    logic [15:0] rx_got [16];
    int          snap [16];

    // entry: [32] ctl_mode_n, [31:16] tx seed, [15:0] din seed
    localparam logic [32:0] VEC [4] = '{
        {1'b0, 16'hA5C3, 16'h0F0F},
        {1'b1, 16'hFFFF, 16'hFFFF},
        {1'b0, 16'h8001, 16'h7FFE},
        {1'b1, 16'h0000, 16'h1234}
    };

    tdm_slot_port #(.BCLK_HALF(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .ctl_mode_n(ctl_mode_n),
        .bclk_i(bclk_i), .fsync_i(fsync_i), .din(din), .bclk_o(bclk_o),
        .fsync_o(fsync_o), .dout(dout), .tx_words(tx_words), .rx_valid(rx_valid),
        .rx_slot(rx_slot), .rx_word(rx_word)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_total[rx_slot] = rx_total[rx_slot] + 1;
            rx_got[rx_slot]   = rx_word;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end

    function automatic logic [15:0] mix(input logic [15:0] seed, input int s);
        return seed ^ (16'(s) * 16'h1111);
    endfunction

    function automatic logic [15:0] exp_tx(input int s, input logic cn);
        if (s >= 10 || (s < 2 && cn)) return 16'h0000;
        return tx_words[s*16 +: 16];
    endfunction

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_slave(input logic d, input logic fs, output logic q);
        @(negedge clk);
        bclk_i = 1'b1; din = d; fsync_i = fs;
        repeat (7) @(negedge clk);
        q = dout;
        @(negedge clk);
        bclk_i = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    task automatic fill(input logic [15:0] txs, input logic [15:0] dins);
        for (int s = 0; s < 10; s++) tx_words[s*16 +: 16] = mix(txs, s);
        for (int s = 0; s < 16; s++) din_w[s] = mix(dins, s);
    endtask

    task automatic run_frame(input logic with_sync);
        logic q;
        if (with_sync) bit_slave(1'b0, 1'b1, q);
        for (int s = 0; s < 16; s++)
            for (int b = 15; b >= 0; b--) begin
                bit_slave(din_w[s][b], 1'b0, q);
                got_dout[s][b] = q;
            end
    endtask

    task automatic check_tx(input string ctx);
        for (int s = 0; s < 16; s++) begin
            if (s >= 10)
                chk_eq({"R5 vacant slot ", ctx}, 32'(got_dout[s]), 32'(exp_tx(s, ctl_mode_n)));
            else if (s < 2 && ctl_mode_n)
                chk_eq({"R5 muted ctl slot ", ctx}, 32'(got_dout[s]), 32'(exp_tx(s, ctl_mode_n)));
            else
                chk_eq({"R4 R3 tx word ", ctx}, 32'(got_dout[s]), 32'(exp_tx(s, ctl_mode_n)));
        end
    endtask

    task automatic check_rx(input string ctx);
        for (int s = 0; s < 16; s++) begin
            int want;
            want = (s < 2) ? (ctl_mode_n ? 0 : 1) : (s < 10 ? 1 : 0);
            chk_eq({"R6 strobe count ", ctx}, 32'(rx_total[s] - snap[s]), 32'(want));
            if (want == 1)
                chk_eq({"R3 R6 rx word ", ctx}, 32'(rx_got[s]), 32'(din_w[s]));
        end
    endtask

    task automatic take_snap();
        for (int s = 0; s < 16; s++) snap[s] = rx_total[s];
    endtask

    initial begin
        logic q;
        int   bad, hi, nclk, fs_hits, fs_pos;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R8 reset state, R7 generator quiet in slave mode
        chk_eq("R8 reset dout", 32'(dout), 0);
        chk_eq("R8 reset rx_valid", 32'(rx_valid), 0);
        chk_eq("R7 slave bclk_o", 32'(bclk_o), 0);
        chk_eq("R7 slave fsync_o", 32'(fsync_o), 0);

        // R8 clocking with no frame marker: no output, no strobes
        take_snap();
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            bit_slave(1'b1, 1'b0, q);
            if (q !== 1'b0) bad++;
        end
        chk_eq("R8 dout before sync", 32'(bad), 0);
        bad = 0;
        for (int s = 0; s < 16; s++) bad += rx_total[s] - snap[s];
        chk_eq("R8 strobes before sync", 32'(bad), 0);

        // vector table: R1 R3 R4 R5 R6
        for (int v = 0; v < 4; v++) begin
            ctl_mode_n = VEC[v][32];
            fill(VEC[v][31:16], VEC[v][15:0]);
            take_snap();
            run_frame(1'b1);
            check_tx($sformatf("vec%0d", v));
            check_rx($sformatf("vec%0d", v));
        end

        // R1 wrap with no new marker
        take_snap();
        run_frame(1'b0);
        check_tx("R1 wrap");
        check_rx("R1 wrap");

        // R2 early marker: abort mid slot 2, then a full frame
        ctl_mode_n = 1'b0;
        fill(16'h3C96, 16'hC3A5);
        bit_slave(1'b0, 1'b1, q);
        for (int i = 0; i < 40; i++) bit_slave(1'b1, 1'b0, q);
        take_snap();
        run_frame(1'b1);
        check_tx("R2 resync");
        check_rx("R2 resync");

        // R7 master mode
        rst_n = 1'b0;
        master_en = 1'b1;
        din = 1'b0;
        ctl_mode_n = 1'b0;
        fill(16'h5A5A, 16'h0000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        while (!fsync_o) @(negedge clk);
        hi = 0;
        while (fsync_o) begin hi++; @(negedge clk); end
        chk_eq("R7 fsync width in clocks", 32'(hi), 8);
        chk_eq("R7 bclk high at frame start", 32'(bclk_o), 1);
        nclk = 0; fs_hits = 0; fs_pos = -1;
        for (int b = 0; b < 256; b++) begin
            while (bclk_o) begin nclk++; @(negedge clk); end
            got_dout[b / 16][15 - (b % 16)] = dout;
            if (fsync_o) begin fs_hits++; fs_pos = b; end
            while (!bclk_o) begin nclk++; @(negedge clk); end
        end
        chk_eq("R7 R1 frame length in clocks", 32'(nclk), 2048);
        chk_eq("R7 fsync periods per frame", 32'(fs_hits), 1);
        chk_eq("R7 fsync on bit 255", 32'(fs_pos), 255);
        check_tx("R7 master");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule